// File: doc/BRIEF.md
# DRAM-side performance counter unit with shared ID filter

This block sits beside a DRAM controller and turns the controller's performance strobes and its accepted-burst information into four counters that software reads back. Counter 0 is the measurement window. It advances on every running cycle, and its select field has no effect on it. When counter 0 rolls over from all-ones to zero, the whole bank locks and an interrupt is raised. Counters 1 to 3 each take an event code from their own select field. A code can pick one raw strobe, or it can pick read or write bursts whose AXI ID passes a masked comparator. One comparator is shared by all counters.

Software clears the bank, sets up the select fields and the filter, then raises the run input. When the interrupt arrives it reads the frozen values. A clear pulse zeroes every counter, releases the lock and drops the interrupt. In enhanced mode the filtered burst events add the burst's byte count instead of one, so the counter measures traffic volume rather than burst count.

Top module: `ddr_perf_counters`

## Requirements
- R1: After reset all counter values are zero, `frozen` is 0 and `irq` is 0.
- R2: While `run_en` is 0, no counter changes value (a clear pulse still zeroes them).
- R3: While running and not frozen, counter 0 rises by one every clock cycle, whatever value its select field (`evt_sel[7:0]`) holds.
- R4: On the cycle counter 0 steps from all-ones to zero, `frozen` and `irq` are set. From then on no counter changes until a clear.
- R5: `irq` stays high until `clr` is pulsed. A `clr` pulse zeroes all counters and drops `frozen` and `irq`, and it takes priority over counting in the same cycle.
- R6: For counter i (1..3), a select code below NUM_EVT (`evt_sel[8*i+7:8*i]`) adds one on each running cycle in which `perf_evt[code]` is high.
- R7: Counters 1 to 3 wrap modulo 2^CNT_W on overflow and never affect `irq` or `frozen`.
- R8: Code 0x41 counts cycles with `bst_valid`=1, `bst_write`=0 and an ID that passes the filter.
- R9: Code 0x42 counts cycles with `bst_valid`=1, `bst_write`=1 and an ID that passes the filter.
- R10: An ID passes when `(bst_id & filt_mask) == (filt_id & filt_mask)`. A mask bit of 1 compares that bit, so a mask of zero passes every ID.
- R11: With `enh_mode`=1, codes 0x41 and 0x42 add `bst_bytes` instead of one. Strobe codes still add one.
- R12: Any other code (NUM_EVT..0x40, 0x43..0xFF) leaves that counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counting enable (start bit) |
| clr | input | 1 | Clear pulse: zero counters, release lock, drop interrupt |
| enh_mode | input | 1 | Filtered events add byte counts |
| evt_sel | input | NUM_CNT*SEL_W | Per-counter event code, counter i in bits [SEL_W*i +: SEL_W] |
| filt_id | input | ID_W | Shared filter ID value |
| filt_mask | input | ID_W | Shared filter mask, 1 = compare bit |
| perf_evt | input | NUM_EVT | Performance strobes from the controller |
| bst_valid | input | 1 | A burst is accepted this cycle |
| bst_write | input | 1 | Accepted burst is a write (0 = read) |
| bst_id | input | ID_W | AXI ID of the accepted burst |
| bst_bytes | input | BYTES_W | Byte count of the accepted burst |
| cnt_out | output | NUM_CNT*CNT_W | Counter values, counter i in bits [CNT_W*i +: CNT_W] |
| frozen | output | 1 | Bank locked after counter 0 expiry |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
Directed runs cover the following cases:
- Strobe codes against toggled strobes, and unsupported codes at the table edges.
- Filtered read and write bursts with IDs that differ only in masked bits, IDs that differ in compared bits, and a zero mask. These separate a correct mask from an ignored or inverted one, and they also show whether the read/write direction is honoured.
- Enhanced mode with large byte counts, which forces counters 1 to 3 to wrap while the interrupt stays low.
- A full window run to counter 0 expiry, followed by further events, which shows that the lock holds and the interrupt is sticky until a clear.

A long random phase then mixes every code, random masks, run gaps and clear pulses against a cycle-accurate bench model.

// File: rtl/ddr_perf_counters.sv
module ddr_perf_counters #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 16,
  parameter int ID_W    = 16,
  parameter int BYTES_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_en,
  input  logic                     clr,
  input  logic                     enh_mode,
  input  logic [NUM_CNT*SEL_W-1:0] evt_sel,
  input  logic [ID_W-1:0]          filt_id,
  input  logic [ID_W-1:0]          filt_mask,
  input  logic [NUM_EVT-1:0]       perf_evt,
  input  logic                     bst_valid,
  input  logic                     bst_write,
  input  logic [ID_W-1:0]          bst_id,
  input  logic [BYTES_W-1:0]       bst_bytes,
  output logic [NUM_CNT*CNT_W-1:0] cnt_out,
  output logic                     frozen,
  output logic                     irq
);
  // NUM_EVT must stay at or below 0x41 so strobe codes and filter codes do not overlap.
  localparam int EVT_IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [SEL_W-1:0] RD_CODE = SEL_W'(8'h41);
  localparam logic [SEL_W-1:0] WR_CODE = SEL_W'(8'h42);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] inc;
  logic frozen_q, irq_q;

  wire id_hit  = (((bst_id ^ filt_id) & filt_mask) == '0);
  wire rd_hit  = bst_valid & ~bst_write & id_hit;
  wire wr_hit  = bst_valid &  bst_write & id_hit;
  wire advance = run_en & ~frozen_q;
  wire [CNT_W-1:0] bump = enh_mode ? CNT_W'(bst_bytes) : CNT_W'(1);

  function automatic logic [CNT_W-1:0] pick(input logic [SEL_W-1:0] sel,
                                            input logic [NUM_EVT-1:0] ev,
                                            input logic rd, input logic wr,
                                            input logic [CNT_W-1:0] amt);
    logic [CNT_W-1:0] r;
    r = '0;
    if (sel < SEL_W'(NUM_EVT)) r = CNT_W'(ev[sel[EVT_IW-1:0]]);
    else if (sel == RD_CODE)   r = rd ? amt : '0;
    else if (sel == WR_CODE)   r = wr ? amt : '0;
    return r;
  endfunction

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_inc
    if (i == 0) begin : g_timer
      assign inc[i] = CNT_W'(1);
    end else begin : g_evt
      assign inc[i] = pick(evt_sel[SEL_W*i +: SEL_W], perf_evt, rd_hit, wr_hit, bump);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (clr) begin
      cnt_q    <= '0;
      frozen_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (advance) begin
      for (int k = 0; k < NUM_CNT; k++) cnt_q[k] <= cnt_q[k] + inc[k];
      if (cnt_q[0] == CNT_MAX) begin
        frozen_q <= 1'b1;
        irq_q    <= 1'b1;
      end
    end
  end

  assign cnt_out = cnt_q;
  assign frozen  = frozen_q;
  assign irq     = irq_q;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr) |=> $stable(cnt_out));

  a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !frozen && !clr) |=> cnt_out[CNT_W-1:0] == CNT_W'($past(cnt_out[CNT_W-1:0]) + 1'b1));

  a_r4_expiry_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !frozen && !clr && cnt_out[CNT_W-1:0] == CNT_MAX) |=> (frozen && irq));

  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr) |=> $stable(cnt_out));

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_out == '0 && !frozen && !irq));

  a_r7_no_irq_without_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(run_en && !frozen && cnt_out[CNT_W-1:0] == CNT_MAX)) |=> !irq);
endmodule

// File: tb/tb_ddr_perf_counters.sv
module tb_ddr_perf_counters;
  localparam int NC = 4, CW = 8, SW = 8, NE = 16, IW = 6, BW = 8;

  logic clk = 0, rst_n = 0, run_en = 0, clr = 0, enh_mode = 0;
  logic [NC*SW-1:0] evt_sel = '0;
  logic [IW-1:0] filt_id = '0, filt_mask = '0, bst_id = '0;
  logic [NE-1:0] perf_evt = '0;
  logic bst_valid = 0, bst_write = 0;
  logic [BW-1:0] bst_bytes = '0;
  logic [NC*CW-1:0] cnt_out;
  logic frozen, irq;

  ddr_perf_counters #(.NUM_CNT(NC), .CNT_W(CW), .SEL_W(SW), .NUM_EVT(NE),
    .ID_W(IW), .BYTES_W(BW)) dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [CW-1:0] m_cnt [NC];
  logic m_frz = 0, m_irq = 0;

  function automatic logic [CW-1:0] m_inc(int idx);
    logic [SW-1:0] s;
    logic pass;
    s = evt_sel[SW*idx +: SW];
    pass = ((bst_id & filt_mask) == (filt_id & filt_mask));
    if (idx == 0) return 1;
    if (s < NE) return CW'(perf_evt[s]);
    if (s == 8'h41 && bst_valid && !bst_write && pass) return enh_mode ? CW'(bst_bytes) : 1;
    if (s == 8'h42 && bst_valid && bst_write && pass) return enh_mode ? CW'(bst_bytes) : 1;
    return 0;
  endfunction

  task automatic compare(string tag);
    logic [NC*CW-1:0] e;
    for (int i = 0; i < NC; i++) e[CW*i +: CW] = m_cnt[i];
    checks++;
    if (cnt_out !== e || frozen !== m_frz || irq !== m_irq) begin
      errors++;
      $display("FAIL %s: cnt=%h frz=%b irq=%b expected cnt=%h frz=%b irq=%b",
               tag, cnt_out, frozen, irq, e, m_frz, m_irq);
    end
  endtask

  task automatic tick(string tag);
    logic [CW-1:0] nx [NC];
    logic expire;
    expire = 0;
    for (int i = 0; i < NC; i++) nx[i] = m_cnt[i];
    if (clr) begin
      for (int i = 0; i < NC; i++) nx[i] = '0;
    end else if (run_en && !m_frz) begin
      expire = (m_cnt[0] == '1);
      for (int i = 0; i < NC; i++) nx[i] = m_cnt[i] + m_inc(i);
    end
    @(posedge clk); #1;
    for (int i = 0; i < NC; i++) m_cnt[i] = nx[i];
    if (clr) begin m_frz = 0; m_irq = 0; end
    else if (expire) begin m_frz = 1; m_irq = 1; end
    compare(tag);
  endtask

  task automatic do_clear(string tag);
    clr = 1; tick(tag); clr = 0;
  endtask

  task automatic burst(logic w, logic [IW-1:0] id, logic [BW-1:0] b);
    bst_valid = 1; bst_write = w; bst_id = id; bst_bytes = b;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NC; i++) m_cnt[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare("R1 reset state");

    perf_evt = '1; evt_sel = {8'd5, 8'd2, 8'd1, 8'd0};
    repeat (5) tick("R2 no count while stopped");

    run_en = 1; evt_sel[7:0] = 8'h41;
    repeat (6) tick("R3 timer ignores its select");
    evt_sel[7:0] = 8'h7F;
    repeat (3) tick("R3 timer ignores its select");
    do_clear("R5 clear zeroes");

    evt_sel = {8'd15, 8'd7, 8'd3, 8'd0};
    for (int k = 0; k < 20; k++) begin
      perf_evt = NE'(k * 16'h1111 ^ 16'h8421);
      tick("R6 strobe codes");
    end
    perf_evt = '0;
    do_clear("R5 clear zeroes");

    filt_id = 6'h15; filt_mask = 6'h3C;
    evt_sel = {8'h42, 8'h42, 8'h41, 8'd0};
    burst(0, 6'h16, 0); tick("R8 read passes, masked bits differ");
    burst(0, 6'h05, 0); tick("R10 compared bit differs");
    burst(1, 6'h14, 0); tick("R9 write passes");
    burst(1, 6'h35, 0); tick("R10 compared bit differs");
    burst(0, 6'h15, 0); tick("R9 read ignored by write code");
    filt_mask = '0;
    burst(1, 6'h2A, 0); tick("R10 zero mask passes all");
    burst(0, 6'h01, 0); tick("R10 zero mask passes all");
    bst_valid = 0; tick("R8 no burst");

    enh_mode = 1; filt_mask = 6'h3F; filt_id = 6'h09;
    evt_sel = {8'd4, 8'h42, 8'h41, 8'd0};
    perf_evt = 16'h0010;
    burst(0, 6'h09, 8'd37); tick("R11 read byte count");
    burst(1, 6'h09, 8'd90); tick("R11 write byte count, strobe adds one");
    burst(1, 6'h08, 8'd90); tick("R11 mismatch adds nothing");
    perf_evt = '0;
    for (int k = 0; k < 6; k++) begin
      burst(k[0], 6'h09, 8'd200); tick("R7 silent wrap");
    end
    bst_valid = 0; enh_mode = 0;

    perf_evt = '1;
    evt_sel = {8'h40, 8'hFF, 8'd16, 8'd0};
    burst(0, 6'h09, 8'd1);
    repeat (4) tick("R12 unsupported codes hold");
    evt_sel = {8'h43, 8'h80, 8'h3F, 8'd0};
    repeat (4) tick("R12 unsupported codes hold");
    bst_valid = 0;

    do_clear("R5 clear zeroes");
    evt_sel = {8'd1, 8'd2, 8'd3, 8'd0};
    perf_evt = '1;
    repeat (260) tick("R4 expiry and freeze");
    repeat (10) tick("R4 frozen holds");
    run_en = 0;
    repeat (3) tick("R5 irq sticky");
    run_en = 1;
    do_clear("R5 clear releases lock");
    repeat (3) tick("R3 counts after clear");

    for (int k = 0; k < 3000; k++) begin
      run_en    = ($urandom_range(0, 7) != 0);
      clr       = ($urandom_range(0, 99) == 0);
      enh_mode  = $urandom_range(0, 1);
      perf_evt  = NE'($urandom);
      for (int i = 1; i < NC; i++) begin
        case ($urandom_range(0, 4))
          0, 1: evt_sel[SW*i +: SW] = 8'h41 + SW'($urandom_range(0, 1));
          2, 3: evt_sel[SW*i +: SW] = SW'($urandom_range(0, NE - 1));
          default: evt_sel[SW*i +: SW] = SW'($urandom);
        endcase
      end
      if (k % 50 == 0) begin
        filt_id = IW'($urandom); filt_mask = IW'($urandom);
      end
      bst_valid = $urandom_range(0, 1); bst_write = $urandom_range(0, 1);
      bst_id = IW'($urandom); bst_bytes = BW'($urandom);
      if ($urandom_range(0, 1)) bst_id = (filt_id & filt_mask) | (bst_id & ~filt_mask);
      tick("R6 R8 R9 R10 R11 random mix");
    end
    clr = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule